// File: doc/BRIEF.md
# NAND Bus Width Access Adapter

This block sits between a processor-side register port and a NAND-style device bus on one chip-select. A request names a target window (command, address or data), an access size of one, two or four bytes, a direction and write data, and it comes with the chip-select's configuration word. The adapter turns that request into an ordered series of device beats. Each beat is a byte on a narrow device or a halfword on a wide one. During command and address writes it raises the matching latch enable.

Write data is sent lowest lane first. Read beats are collected into increasing lanes of a word-wide result. That result is held steady after the request completes, so the requester can pick it up at any later time. Each beat is a strobe and ready handshake with the device. The requester sees one done pulse per accepted request.

Top module: `nand_width_adapter`

## Requirements
- R1: A request whose chip-select type field (config bits [11:10]) is not 2 causes no device beat. It completes with a done pulse on the clock after acceptance, and the read data output is zero.
- R2: Config bit 12 set to 1 selects the wide (halfword) device, and 0 selects the narrow (byte) device. Bit 13 has no effect on width.
- R3: Size code 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. A write to a narrow device gives 1, 2 or 4 beats. Each beat carries the next byte of write data, lowest first, on dev_dout[7:0], and dev_dout[15:8] is zero.
- R4: A four-byte write to a wide device gives two beats, low half first. A one- or two-byte write gives a single beat carrying write data bits [15:0].
- R5: Window code 0 (command) asserts dev_cle and code 1 (address) asserts dev_ale, during every write beat of the request. Codes 2 and 3 (data) assert neither. The two enables are never high together, and neither is high without dev_we.
- R6: A read from a narrow device performs 1, 2 or 4 beats by size code. Beat i places dev_din[7:0] into result byte lane i, and lanes not read are zero.
- R7: A four-byte read from a wide device performs two beats into halfword lanes 0 and 1. A one- or two-byte read performs one halfword beat into bits [15:0], and the upper half is zero.
- R8: A read aimed at the command or address window causes no device beat. It completes with a done pulse and a zero result.
- R9: A beat completes on a clock edge where its strobe and dev_ready are both high. Until then the strobe, latch enables and dev_dout hold steady, and req_ready is low while any strobe is high.
- R10: req_done is high for exactly one cycle, on the clock after the final beat completes. req_rdata keeps its value from then until the next request is accepted, and a write leaves it zero.
- R11: After reset the adapter is idle: req_ready high, and req_done, dev_we, dev_re, dev_cle, dev_ale and req_rdata all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request accepted when valid |
| req_kind | input | 2 | Window: 0 command, 1 address, 2/3 data |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| cs_cfg | input | 32 | Chip-select configuration word |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Gathered read data |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_we | output | 1 | Write strobe |
| dev_re | output | 1 | Read strobe |
| dev_dout | output | 16 | Device write data |
| dev_din | input | 16 | Device read data |
| dev_ready | input | 1 | Device accepts or delivers the current beat |

## Verification
The embedded properties check on every cycle that the strobes hold steady until ready, that the two latch enables are exclusive and only appear with the write strobe, that the request side is busy while a strobe is high, that done follows the final beat by one clock, and that the read result only moves on a clear or a captured beat. Beat counts, lane ordering, the zeroed upper lanes, the effect of each window on the latch enables, and the cases where a request is ignored for type or direction can only be shown by the bench. It compares a logged sequence of device beats and the final result against values computed from each request under random ready delays.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

   typedef enum logic [1:0] {
      WIN_CMD      = 2'd0,
      WIN_ADDR     = 2'd1,
      WIN_DATA     = 2'd2,
      WIN_DATA_ALT = 2'd3
   } win_e;

   typedef enum logic [1:0] {
      SZ_BYTE     = 2'd0,
      SZ_HALF     = 2'd1,
      SZ_WORD     = 2'd2,
      SZ_WORD_ALT = 2'd3
   } size_e;

   // Decoded description of one accepted request
   typedef struct packed {
      logic       go;     // device beats are needed
      logic       wide;   // halfword device
      logic       write;
      logic       cle;
      logic       ale;
      logic [1:0] last;   // index of the final beat
   } plan_t;

endpackage

// File: rtl/nwa_plan.sv
module nwa_plan
   import nwa_pkg::*;
#(
   parameter logic [1:0] NAND_CODE = 2'd2
) (
   input  logic [1:0] dev_type,
   input  logic       dev_wide,
   input  logic [1:0] kind,
   input  logic [1:0] size,
   input  logic       write,
   output plan_t      plan
);

   logic is_nand;
   logic ctl_read;

   always_comb begin
      is_nand    = (dev_type == NAND_CODE);
      ctl_read   = !write && (kind == WIN_CMD || kind == WIN_ADDR);
      plan.go    = is_nand && !ctl_read;
      plan.wide  = dev_wide;
      plan.write = write;
      plan.cle   = write && (kind == WIN_CMD);
      plan.ale   = write && (kind == WIN_ADDR);
      if (dev_wide) begin
         plan.last = size[1] ? 2'd1 : 2'd0;
      end else begin
         plan.last = size[1] ? 2'd3 : (size[0] ? 2'd1 : 2'd0);
      end
   end

endmodule

// File: rtl/nwa_seq.sv
module nwa_seq
   import nwa_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  plan_t      plan,
   input  logic       dev_ready,
   output logic       busy,
   output plan_t      plan_q,
   output logic [1:0] idx,
   output logic       beat,
   output logic       done
);

   logic final_beat;

   assign beat       = busy && dev_ready;
   assign final_beat = beat && (idx == plan_q.last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         plan_q <= '0;
         idx    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            plan_q <= plan;
            idx    <= '0;
            if (plan.go) begin
               busy <= 1'b1;
            end else begin
               done <= 1'b1;
            end
         end else if (beat) begin
            idx <= idx + 2'd1;
            if (final_beat) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R9: an unanswered beat keeps its position
   p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dev_ready) |=> (busy && $stable(idx)));

   // R10: completion pulse follows the final beat
   p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      final_beat |=> (done && !busy));

endmodule

// File: rtl/nwa_gather.sv
module nwa_gather #(
   parameter int DEV_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               capture,
   input  logic               wide,
   input  logic [1:0]         idx,
   input  logic [DEV_W-1:0]   din,
   output logic [2*DEV_W-1:0] rdata
);

   localparam int LANE_W = DEV_W / 2;
   localparam int LANES  = 4;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [1:0] NARROW_IDX = 2'(l);
      localparam logic [1:0] WIDE_IDX   = 2'(l / 2);
      localparam int         SRC_LO     = (l % 2) * LANE_W;
      logic hit;
      assign hit = capture && (wide ? (idx == WIDE_IDX) : (idx == NARROW_IDX));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata[l*LANE_W +: LANE_W] <= '0;
         end else if (clear) begin
            rdata[l*LANE_W +: LANE_W] <= '0;
         end else if (hit) begin
            rdata[l*LANE_W +: LANE_W] <= wide ? din[SRC_LO +: LANE_W]
                                              : din[LANE_W-1:0];
         end
      end
   end

   // R10: the result moves only on a clear or a captured beat
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !capture) |=> $stable(rdata));

   // R10: a clear leaves an all-zero result
   p_rdata_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (rdata == '0));

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
   import nwa_pkg::*;
#(
   parameter int         DEV_W     = 16,
   parameter int         CFG_W     = 32,
   parameter int         TYPE_LSB  = 10,
   parameter int         WIDE_BIT  = 12,
   parameter logic [1:0] NAND_CODE = 2'd2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [1:0]         req_kind,
   input  logic [1:0]         req_size,
   input  logic               req_write,
   input  logic [2*DEV_W-1:0] req_wdata,
   input  logic [CFG_W-1:0]   cs_cfg,
   output logic               req_done,
   output logic [2*DEV_W-1:0] req_rdata,
   output logic               dev_cle,
   output logic               dev_ale,
   output logic               dev_we,
   output logic               dev_re,
   output logic [DEV_W-1:0]   dev_dout,
   input  logic [DEV_W-1:0]   dev_din,
   input  logic               dev_ready
);

   localparam int LANE_W = DEV_W / 2;
   localparam int WORD_W = 2 * DEV_W;

   if (DEV_W < 2 || (DEV_W % 2) != 0) begin : g_bad_dev_w
      $error("DEV_W must be even and at least 2");
   end
   if (TYPE_LSB + 1 >= CFG_W || WIDE_BIT >= CFG_W) begin : g_bad_cfg_pos
      $error("config field positions exceed CFG_W");
   end
   if (WIDE_BIT == TYPE_LSB || WIDE_BIT == TYPE_LSB + 1) begin : g_bad_overlap
      $error("width bit overlaps the type field");
   end

   plan_t              plan;
   plan_t              plan_q;
   logic               busy;
   logic               start;
   logic [1:0]         idx;
   logic               beat;
   logic [WORD_W-1:0]  wdata_q;
   logic               unused_cfg;

   assign unused_cfg = ^cs_cfg;
   assign req_ready  = !busy;
   assign start      = req_valid && !busy;

   nwa_plan #(.NAND_CODE(NAND_CODE)) u_plan (
      .dev_type (cs_cfg[TYPE_LSB +: 2]),
      .dev_wide (cs_cfg[WIDE_BIT]),
      .kind     (req_kind),
      .size     (req_size),
      .write    (req_write),
      .plan     (plan)
   );

   nwa_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .plan      (plan),
      .dev_ready (dev_ready),
      .busy      (busy),
      .plan_q    (plan_q),
      .idx       (idx),
      .beat      (beat),
      .done      (req_done)
   );

   nwa_gather #(.DEV_W(DEV_W)) u_gather (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .capture (beat && !plan_q.write),
      .wide    (plan_q.wide),
      .idx     (idx),
      .din     (dev_din),
      .rdata   (req_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
      end else if (start) begin
         wdata_q <= req_wdata;
      end
   end

   always_comb begin
      if (plan_q.wide) begin
         dev_dout = wdata_q[idx[0]*DEV_W +: DEV_W];
      end else begin
         dev_dout = {{(DEV_W-LANE_W){1'b0}}, wdata_q[idx*LANE_W +: LANE_W]};
      end
   end

   assign dev_we  = busy && plan_q.write;
   assign dev_re  = busy && !plan_q.write;
   assign dev_cle = busy && plan_q.cle;
   assign dev_ale = busy && plan_q.ale;

   // R5: latch enables are exclusive
   p_latch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_cle && dev_ale));

   // R5: a latch enable only accompanies a write strobe
   p_latch_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_cle || dev_ale) |-> dev_we);

   // R9: device-side signals hold while the beat waits
   p_dev_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_we || dev_re) && !dev_ready) |=>
         ($stable(dev_we) && $stable(dev_re) && $stable(dev_dout)
          && $stable(dev_cle) && $stable(dev_ale)));

   // R9: no new request is taken while a strobe is active
   p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_we || dev_re) |-> !req_ready);

endmodule

// File: tb/nand_width_adapter_bench.sv
module nand_width_adapter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [31:0] cs_cfg = '0;
   logic        req_done;
   logic [31:0] req_rdata;
   logic        dev_cle, dev_ale, dev_we, dev_re;
   logic [15:0] dev_dout;
   logic [15:0] dev_din = '0;
   logic        dev_ready = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   logic [15:0] lg_dout [8];
   logic        lg_cle [8];
   logic        lg_ale [8];
   logic        lg_we [8];
   logic [15:0] rd_pat [8];
   int          lg_n = 0;
   bit          acc = 0;
   int          wcnt = 0;

   always #2 clk = ~clk;

   nand_width_adapter u_nand_width_adapter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_size(req_size), .req_write(req_write),
      .req_wdata(req_wdata), .cs_cfg(cs_cfg), .req_done(req_done),
      .req_rdata(req_rdata), .dev_cle(dev_cle), .dev_ale(dev_ale),
      .dev_we(dev_we), .dev_re(dev_re), .dev_dout(dev_dout),
      .dev_din(dev_din), .dev_ready(dev_ready)
   );

   // Beat logger
   always @(posedge clk) begin
      if (rst_n && dev_ready && (dev_we || dev_re)) begin
         if (lg_n < 8) begin
            lg_dout[lg_n] = dev_dout;
            lg_cle[lg_n]  = dev_cle;
            lg_ale[lg_n]  = dev_ale;
            lg_we[lg_n]   = dev_we;
         end
         lg_n = lg_n + 1;
         acc  = 1;
      end
   end

   // Device model with random ready delay
   always @(negedge clk) begin
      if (acc) begin
         acc       = 0;
         dev_ready = 1'b0;
         wcnt      = $urandom % 3;
      end
      if ((dev_we || dev_re) && !dev_ready) begin
         if (wcnt == 0) begin
            dev_ready = 1'b1;
            dev_din   = rd_pat[lg_n % 8];
         end else begin
            wcnt = wcnt - 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic int exp_beats(input logic [31:0] cfg, input logic [1:0] kind,
                                    input logic [1:0] size, input logic wr);
      if (cfg[11:10] != 2'd2) return 0;
      if (!wr && kind < 2) return 0;
      if (cfg[12]) return size[1] ? 2 : 1;
      return size[1] ? 4 : (size[0] ? 2 : 1);
   endfunction

   function automatic logic [15:0] exp_dout(input logic wide, input logic [31:0] wd,
                                            input int i);
      if (wide) return wd[16*i +: 16];
      return {8'h00, wd[8*i +: 8]};
   endfunction

   function automatic logic [31:0] exp_rd(input logic wide, input int nb);
      logic [31:0] r = '0;
      for (int i = 0; i < nb; i++) begin
         if (wide) r[16*i +: 16] = rd_pat[i];
         else      r[8*i +: 8]   = rd_pat[i][7:0];
      end
      return r;
   endfunction

   task automatic do_req(input logic [1:0] kind, input logic [1:0] size,
                         input logic wr, input logic [31:0] wd,
                         input logic [31:0] cfg);
      int    nb;
      int    waitc;
      string tag;
      logic  wide;
      logic [31:0] er;
      nb   = exp_beats(cfg, kind, size, wr);
      wide = cfg[12];
      if (cfg[11:10] != 2'd2)  tag = "R1";
      else if (!wr && kind < 2) tag = "R8";
      else if (wr)  tag = wide ? "R4" : "R3";
      else          tag = wide ? "R7" : "R6";
      for (int i = 0; i < 8; i++) rd_pat[i] = 16'($urandom);
      lg_n      = 0;
      req_kind  = kind;
      req_size  = size;
      req_write = wr;
      req_wdata = wd;
      cs_cfg    = cfg;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      waitc = 0;
      while (!req_done && waitc < 200) begin
         @(negedge clk);
         waitc++;
      end
      check(req_done == 1'b1, "R10", "done seen", 32'(req_done), 32'd1);
      check(lg_n == nb, tag, "beat count", 32'(lg_n), 32'(nb));
      for (int i = 0; i < nb && i < lg_n && i < 8; i++) begin
         check(lg_we[i] == wr, "R9", "strobe kind", 32'(lg_we[i]), 32'(wr));
         if (wr) begin
            check(lg_dout[i] == exp_dout(wide, wd, i), tag, "beat data",
                  32'(lg_dout[i]), 32'(exp_dout(wide, wd, i)));
            check(lg_cle[i] == (kind == 2'd0) && lg_ale[i] == (kind == 2'd1),
                  "R5", "latch enables", {lg_cle[i], lg_ale[i]},
                  {30'd0, kind == 2'd0, kind == 2'd1});
         end
      end
      er = (wr || nb == 0) ? 32'd0 : exp_rd(wide, nb);
      check(req_rdata == er, tag, "read result", req_rdata, er);
      @(negedge clk);
      check(req_done == 1'b0, "R10", "done single cycle", 32'(req_done), 32'd0);
      for (int k = 0; k < int'($urandom % 3); k++) @(negedge clk);
      check(req_rdata == er, "R10", "result held", req_rdata, er);
   endtask

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=%0d exp=<150000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(req_ready && !req_done && !dev_we && !dev_re && !dev_cle && !dev_ale,
            "R11", "idle controls",
            {26'd0, req_ready, req_done, dev_we, dev_re, dev_cle, dev_ale},
            32'h20);
      check(req_rdata == 32'd0, "R11", "reset result", req_rdata, 32'd0);

      // Directed corners
      do_req(2'd0, 2'd0, 1'b1, 32'h0000_0070, 32'h0000_0800);  // R5 command byte narrow
      do_req(2'd1, 2'd2, 1'b1, 32'h4433_2211, 32'h0000_0800);  // R3 R5 address word narrow
      do_req(2'd2, 2'd2, 1'b1, 32'hBEEF_CAFE, 32'h0000_1800);  // R4 word wide
      do_req(2'd2, 2'd0, 1'b1, 32'h0000_A55A, 32'h0000_1800);  // R4 byte on wide
      do_req(2'd3, 2'd2, 1'b0, 32'h0,         32'h0000_0800);  // R6 word narrow
      do_req(2'd2, 2'd0, 1'b0, 32'h0,         32'h0000_1800);  // R7 byte read on wide
      do_req(2'd2, 2'd3, 1'b0, 32'h0,         32'h0000_1800);  // R7 word wide
      do_req(2'd2, 2'd1, 1'b0, 32'h0,         32'h0000_2800);  // R2 bit13 only: narrow
      do_req(2'd2, 2'd2, 1'b1, 32'h1234_5678, 32'h0000_0400);  // R1 not nand
      do_req(2'd0, 2'd2, 1'b0, 32'h0,         32'h0000_0800);  // R8 read command window
      do_req(2'd1, 2'd1, 1'b0, 32'h0,         32'h0000_1800);  // R8 read address window

      // Random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] cfg;
         cfg = $urandom;
         if (($urandom % 4) != 0) cfg[11:10] = 2'd2;
         do_req(2'($urandom), 2'($urandom), 1'($urandom), $urandom, cfg);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule